// File: doc/BRIEF.md
# Hold/Toggle Interval Mode Controller

This block gates the per-latch enables of a low-toggle pseudo-random pattern generator so that each pattern's shift time breaks into alternating intervals. In a toggle interval the per-latch control vector passes through: the latches it selects stay transparent and carry fresh generator bits to the phase shifter. In a hold interval every latch enable is forced low, so all phase-shifter inputs freeze whatever the control vector says. A one-bit mode register flips between the two intervals. It flips whenever a weighted random decision fires.

That decision is made from a dedicated group of generator bits. The weight code that governs it depends on the current mode. While toggling, the toggle-length code is used. While holding, the hold-length code is used. Each code bit enables one AND term of 1, 2, 3 or 4 random bits, which fires with probability 1/2, 1/4, 1/8 or 1/16. The enabled terms are ORed, so a code can reach probabilities that are not powers of two. An all-zero hold code switches hold intervals off entirely. A first-cycle strobe, raised at the end of generator initialisation, opens every latch for one cycle and restarts the controller in toggle mode.

All pins are plain control and data levels. The block takes one decision per clock and has no flow control: the generator advances on every clock, so there is nothing to back-pressure.

Top module: `hti_ctrl_top`

## Requirements
- R1: After reset the mode register is 1 (toggle), so `mode_tog` is 1 and `lat_en` equals `ctrl_vec`.
- R2: While `mode_tog` is 1 and `first_cycle` is 0, `lat_en` equals `ctrl_vec` in the same cycle.
- R3: While `mode_tog` is 0 and `first_cycle` is 0, `lat_en` is all zeros whatever `ctrl_vec` holds.
- R4: When the weighted decision fires and `first_cycle` is 0, the mode register inverts at the next clock edge. Otherwise it keeps its value.
- R5: The weighted decision uses `tog_code` while the mode register is 1 and `hold_code` while it is 0. The code that is not selected has no effect.
- R6: Code bit i enables an AND of i+1 bits of `rnd_mode`, taken from bit i*(i+1)/2 upward: bit0 uses [0], bit1 uses [2:1], bit2 uses [5:3] and bit3 uses [9:6]. The decision fires when any enabled term is all ones. A code of 0000 never fires.
- R7: While `hold_code` is 0000, `mode_tog` is 1 and `lat_en` equals `ctrl_vec` (when `first_cycle` is 0), even if the mode register is 0. When `hold_code` becomes nonzero again, the stored mode takes effect.
- R8: While `first_cycle` is 1, `lat_en` is all ones. At the next edge the mode register is 1, even if the weighted decision fires in that cycle.
- R9: `mode_tog` reports the mode register ORed with the no-hold condition (`hold_code` equal to 0000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rnd_mode | input | 10 | Generator bits reserved for the interval decision |
| tog_code | input | 4 | Weight code ending toggle intervals |
| hold_code | input | 4 | Weight code ending hold intervals; 0000 disables hold |
| ctrl_vec | input | 16 | Per-latch toggle enables from the control register |
| first_cycle | input | 1 | End-of-initialisation strobe: reload all latches |
| lat_en | output | 16 | Gated per-latch enables |
| mode_tog | output | 1 | Effective mode, 1 = toggle |

## Verification
The first-cycle strobe and a firing weighted decision can land in the same cycle, and both act on the mode register. The bench raises the strobe with all random bits high and a full toggle code while in toggle mode. It does the same from hold mode with a full hold code. It then checks that the enables are all ones in that cycle and that the next cycle reports toggle mode instead of a flip. The no-hold override is also driven while the stored mode is 0, to show that the override and the stored state are separate.

// File: rtl/hti_pkg.sv
package hti_pkg;
  localparam int unsigned WCODE_W = 4;
  localparam int unsigned RND_W   = WCODE_W * (WCODE_W + 1) / 2;

  function automatic int unsigned grp_base(input int unsigned lvl);
    return lvl * (lvl + 1) / 2;
  endfunction
endpackage

// File: rtl/hti_weight.sv
module hti_weight
  import hti_pkg::*;
#(
  parameter int unsigned CODE_W = WCODE_W,
  localparam int unsigned RBITS = CODE_W * (CODE_W + 1) / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CODE_W-1:0] code,
  input  logic [RBITS-1:0]  rnd,
  output logic              fire
);
  logic [CODE_W-1:0] term;

  for (genvar i = 0; i < CODE_W; i++) begin : g_term
    assign term[i] = code[i] & (&rnd[grp_base(i) +: (i + 1)]);
  end

  assign fire = |term;

  // R6: an all-zero code can never end an interval
  a_r6_zero_code_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (code == '0) |-> !fire);
endmodule

// File: rtl/hti_mode_reg.sv
module hti_mode_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic first_cycle,
  input  logic fire,
  output logic tff_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           tff_q <= 1'b1;
    else if (first_cycle) tff_q <= 1'b1;
    else if (fire)        tff_q <= ~tff_q;
  end

  // R4: a fired decision flips the mode at the next edge
  a_r4_flip_on_fire: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !first_cycle) |=> (tff_q != $past(tff_q)));
  // R4: without a decision the mode is kept
  a_r4_keep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && !first_cycle) |=> $stable(tff_q));
endmodule

// File: rtl/hti_gate.sv
module hti_gate #(
  parameter int unsigned N_LAT = 16
) (
  input  logic             mode,
  input  logic             first_cycle,
  input  logic [N_LAT-1:0] ctrl_vec,
  output logic [N_LAT-1:0] lat_en
);
  for (genvar i = 0; i < N_LAT; i++) begin : g_lat
    assign lat_en[i] = first_cycle | (ctrl_vec[i] & mode);
  end
endmodule

// File: rtl/hti_ctrl_top.sv
module hti_ctrl_top
  import hti_pkg::*;
#(
  parameter int unsigned N_LAT = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RND_W-1:0]   rnd_mode,
  input  logic [WCODE_W-1:0] tog_code,
  input  logic [WCODE_W-1:0] hold_code,
  input  logic [N_LAT-1:0]   ctrl_vec,
  input  logic               first_cycle,
  output logic [N_LAT-1:0]   lat_en,
  output logic               mode_tog
);
  logic               tff_q;
  logic               fire;
  logic               no_hold;
  logic [WCODE_W-1:0] sel_code;

  // per-bit code selection steered by the stored mode
  for (genvar b = 0; b < WCODE_W; b++) begin : g_mux
    assign sel_code[b] = tff_q ? tog_code[b] : hold_code[b];
  end

  assign no_hold  = (hold_code == '0);
  assign mode_tog = tff_q | no_hold;

  hti_weight #(.CODE_W(WCODE_W)) u_weight (
    .clk   (clk),
    .rst_n (rst_n),
    .code  (sel_code),
    .rnd   (rnd_mode),
    .fire  (fire)
  );

  hti_mode_reg u_mode (
    .clk         (clk),
    .rst_n       (rst_n),
    .first_cycle (first_cycle),
    .fire        (fire),
    .tff_q       (tff_q)
  );

  hti_gate #(.N_LAT(N_LAT)) u_gate (
    .mode        (mode_tog),
    .first_cycle (first_cycle),
    .ctrl_vec    (ctrl_vec),
    .lat_en      (lat_en)
  );

  // R3: hold interval blocks every latch
  a_r3_hold_blocks_all: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_tog && !first_cycle) |-> (lat_en == '0));
  // R2: toggle interval passes the control vector
  a_r2_toggle_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_tog && !first_cycle) |-> (lat_en == ctrl_vec));
  // R7: zero hold code keeps the generator toggling
  a_r7_no_hold_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_code == '0) |-> mode_tog);
  // R8: first-cycle strobe opens all latches and restarts in toggle mode
  a_r8_first_all_open: assert property (@(posedge clk) disable iff (!rst_n)
    first_cycle |-> (&lat_en));
  a_r8_first_restart: assert property (@(posedge clk) disable iff (!rst_n)
    first_cycle |=> tff_q);
endmodule

// File: tb/sim_hti_ctrl_top.sv
module sim_hti_ctrl_top;
  localparam int N = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [9:0]    rnd_mode = '0;
  logic [3:0]    tog_code = 4'h1;
  logic [3:0]    hold_code = 4'h1;
  logic [N-1:0]  ctrl_vec = '0;
  logic          first_cycle = 1'b0;
  logic [N-1:0]  lat_en;
  logic          mode_tog;

  int n_cmp = 0;
  int n_bad = 0;
  bit model_t = 1'b1;
  bit done = 1'b0;

  logic [N-1:0] q_en[$];
  logic         q_mode[$];
  string        q_tag[$];

  always #4 clk = ~clk;

  hti_ctrl_top #(.N_LAT(N)) u0 (
    .clk(clk), .rst_n(rst_n), .rnd_mode(rnd_mode), .tog_code(tog_code),
    .hold_code(hold_code), .ctrl_vec(ctrl_vec), .first_cycle(first_cycle),
    .lat_en(lat_en), .mode_tog(mode_tog)
  );

  function automatic bit w_fire(input logic [3:0] c, input logic [9:0] r);
    bit f;
    f = (c[0] && r[0]) || (c[1] && (&r[2:1])) ||
        (c[2] && (&r[5:3])) || (c[3] && (&r[9:6]));
    return f;
  endfunction

  task automatic step(input logic [N-1:0] c, input logic [3:0] h,
                      input logic [3:0] t, input logic [9:0] r,
                      input bit fc, input string tag);
    bit eff;
    @(negedge clk);
    ctrl_vec = c; hold_code = h; tog_code = t; rnd_mode = r; first_cycle = fc;
    eff = model_t | (h == 4'h0);
    q_en.push_back(fc ? {N{1'b1}} : (c & {N{eff}}));
    q_mode.push_back(eff);
    q_tag.push_back(tag);
    if (fc) model_t = 1'b1;
    else if (w_fire(model_t ? t : h, r)) model_t = ~model_t;
  endtask

  // monitor: pops expectations and compares away from the edge
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (q_en.size() > 0) begin
        logic [N-1:0] e_en;
        logic e_m;
        string tg;
        e_en = q_en.pop_front();
        e_m  = q_mode.pop_front();
        tg   = q_tag.pop_front();
        n_cmp++;
        if (lat_en !== e_en || mode_tog !== e_m) begin
          n_bad++;
          $display("FAIL %s: lat_en=%h mode=%b expected lat_en=%h mode=%b",
                   tg, lat_en, mode_tog, e_en, e_m);
        end
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state is toggle mode
    step(16'h00A5, 4'h1, 4'h1, 10'h000, 1'b0, "R1 reset mode");
    // R2: pass-through under several vectors
    step(16'hFFFF, 4'h1, 4'h1, 10'h000, 1'b0, "R2 all ones");
    step(16'h1234, 4'h1, 4'h1, 10'h000, 1'b0, "R2 mixed");
    step(16'h0000, 4'h1, 4'h1, 10'h000, 1'b0, "R2 zero");
    // R6: code bit1 with half of its group set does not fire
    step(16'h0F0F, 4'h1, 4'h2, 10'h002, 1'b0, "R6 partial group");
    step(16'h0F0F, 4'h1, 4'h2, 10'h006, 1'b0, "R6 bit1 group fires");
    // R4/R3: now in hold, all latches blocked
    step(16'hFFFF, 4'h8, 4'h1, 10'h001, 1'b0, "R3 hold blocks / R5 tog unused");
    step(16'hABCD, 4'h8, 4'h1, 10'h1C0, 1'b0, "R3 hold / R6 bit3 short");
    step(16'hABCD, 4'h8, 4'h1, 10'h3C0, 1'b0, "R4 hold ends via bit3");
    step(16'hABCD, 4'h1, 4'h0, 10'h3FF, 1'b0, "R6 zero tog code no flip");
    step(16'h5555, 4'h1, 4'h4, 10'h038, 1'b0, "R6 bit2 group fires");
    // R7: override while stored mode is 0
    step(16'h5555, 4'h0, 4'h4, 10'h3FF, 1'b0, "R7 no-hold override");
    step(16'h3333, 4'h0, 4'hF, 10'h3FF, 1'b0, "R7 no-hold steady");
    step(16'h3333, 4'h2, 4'hF, 10'h000, 1'b0, "R9 stored hold returns");
    // R8: strobe from hold with a firing hold code
    step(16'h0000, 4'hF, 4'hF, 10'h3FF, 1'b1, "R8 strobe from hold");
    step(16'h00F0, 4'h1, 4'h1, 10'h000, 1'b0, "R8 restart toggle");
    // R8: strobe coinciding with a firing toggle code
    step(16'h0000, 4'h1, 4'hF, 10'h3FF, 1'b1, "R8 strobe vs fire");
    step(16'h0F00, 4'h1, 4'h1, 10'h000, 1'b0, "R8 no flip after strobe");
    // mixed stretch
    for (int k = 0; k < 400; k++) begin
      logic [9:0] r;
      r = 10'($urandom) | 10'($urandom);
      step(16'($urandom), 4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)),
           r, ($urandom_range(0, 31) == 0), "R4 R5 mixed");
    end
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule